// File: doc/BRIEF.md
# Modulo 2^256−38 Fold Reducer

This unit takes a 512-bit integer product and returns a 256-bit value congruent to it modulo 2^256 − 38, which is twice the prime 2^255 − 19. The result is only partially reduced: it lies below the modulus word vector supplied at the port, but it is not brought below the prime itself. It sits behind a wide multiplier in an elliptic-curve datapath, where keeping values below twice the prime is enough until the very last step.

The work is done one 32-bit word per cycle in three passes. First, the upper 256 bits are multiplied by 38 and added to the lower 256 bits. The multiply is built from three shifted copies of each upper word (by 1, 2 and 5 bits), each copy taking the spilled-over top bits of the word below it. This pass uses a short pipelined adder tree. Second, the few bits that spill above bit 255 are multiplied by 38 and rippled back into the low words. Third, the modulus is subtracted once, word by word. The difference is kept unless the subtraction borrows out of the top.

A pulse on `start` while the unit is idle captures the product and the modulus. Thirty clock edges later `done` pulses for one cycle, and `result` holds the new value from then until the next completion.

Top module: `mod2p_fold_reducer`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy` and `done` are 0 and `result` is all zeros.
- R2: A `start` accepted at a clock edge makes `busy` go to 1 after that edge and stay 1 for 29 more edges. `done` is 1 for exactly one cycle, after the 30th edge following the accepted start, and `busy` is 0 in that same cycle.
- R3: `start` has no effect while `busy` is 1. The completion timing and the result of the running operation are unchanged.
- R4: With product C (word k in bits [32k+31:32k], words 0–7 low half L, words 8–15 high half H) and modulus N: S1 = L + 38·H and S2 = (S1 mod 2^256) + 38·⌊S1/2^256⌋. `result` is S2 − N when S2 ≥ N and S2 otherwise, taken as 256 bits. For N = 2^256 − 38 this is congruent to C modulo N.
- R5: The conditional subtraction is exact at its boundary. For N = 2^256 − 38, a product equal to N gives 0, a product of N − 1 gives N − 1, and a product of N + 5 gives 5. When N = 2^256 − 38 every result is below N.
- R6: The all-ones 512-bit product is reduced without loss of any carry.
- R7: The bits that the ×2, ×4 and ×32 copies push out of the top of each high word are added into the next word position, including into the position above the top high word.
- R8: `result` changes only in a cycle where `done` is 1.
- R9: The modulus is sampled only when a start is accepted. Changing `modulus_in` while busy has no effect on that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a reduction; accepted only when idle |
| prod_in | input | 512 | Product to reduce, word k in bits [32k+31:32k] |
| modulus_in | input | 256 | Modulus vector, normally 2^256 − 38 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the result is updated |
| result | output | 256 | Partially reduced result |

## Verification
A zero product and values near the modulus (N − 1, N, N + 5) pin down the final keep-or-subtract choice, because they land on either side of the borrow decision. High halves of 0x80000000 and 0xF8000000 repeated in every word show whether the 1-, 2- and 5-bit spill-overs reach the next word and the extra ninth position. The all-ones product drives the largest first-pass overflow, so the second fold and its carry ripple are fully exercised. Random products are checked both against the stated formula and for congruence modulo 2^256 − 38, and two overlapped runs tell a correct design apart from one that restarts on a mid-run start or rereads the modulus port while busy.

// File: rtl/red_pkg.sv
package red_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FOLD1,
    ST_FOLD2,
    ST_SUB,
    ST_FINISH
  } red_state_e;
endpackage

// File: rtl/fold38_pipe.sv
// First pass: adds the low word and three shifted copies of the high words
// (x2, x4, x32) through a three-register adder tree with a word carry.
module fold38_pipe #(
  parameter int WORD_W = 32,
  parameter int EXT_W  = 40,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              issue,
  input  logic [CNT_W-1:0]  idx_in,
  input  logic [WORD_W-1:0] h_cur,
  input  logic [WORD_W-1:0] h_prev,
  input  logic [WORD_W-1:0] l_cur,
  output logic              wr_en,
  output logic [CNT_W-1:0]  wr_idx,
  output logic [WORD_W-1:0] wr_word
);
  localparam int CAR_W = EXT_W - WORD_W;

  logic [WORD_W-1:0] xs [3];

  // one shifted copy per power of two in 38 = 2 + 4 + 32
  for (genvar g = 0; g < 3; g++) begin : g_copy
    localparam int SH = (g == 0) ? 1 : ((g == 1) ? 2 : 5);
    assign xs[g] = (h_cur << SH) | (h_prev >> (WORD_W - SH));
  end

  logic              v1_q, v2_q;
  logic [CNT_W-1:0]  i1_q, i2_q;
  logic [EXT_W-1:0]  t1_q, t2_q, t3_q;
  logic [CAR_W-1:0]  carry_q;
  logic [EXT_W-1:0]  t4;

  assign t4 = t3_q + EXT_W'(carry_q);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      v1_q    <= 1'b0;
      v2_q    <= 1'b0;
      carry_q <= '0;
    end else begin
      v1_q <= issue;
      v2_q <= v1_q;
      if (v2_q) carry_q <= t4[EXT_W-1:WORD_W];
    end
  end

  always_ff @(posedge clk) begin
    i1_q <= idx_in;
    i2_q <= i1_q;
    t1_q <= EXT_W'(xs[0]) + EXT_W'(xs[1]);
    t2_q <= EXT_W'(xs[2]) + EXT_W'(l_cur);
    t3_q <= t1_q + t2_q;
  end

  assign wr_en   = v2_q;
  assign wr_idx  = i2_q;
  assign wr_word = t4[WORD_W-1:0];
endmodule

// File: rtl/fold_carry.sv
// Second pass: ripples a preloaded wide carry through the first-pass words.
module fold_carry #(
  parameter int WORD_W = 32,
  parameter int EXT_W  = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              first,
  input  logic [EXT_W-1:0]  preload,
  input  logic [WORD_W-1:0] y,
  output logic [WORD_W-1:0] sum_word
);
  logic [EXT_W-1:0] carry_q;
  logic [EXT_W-1:0] sum;

  assign sum      = (first ? preload : carry_q) + EXT_W'(y);
  assign sum_word = sum[WORD_W-1:0];

  always_ff @(posedge clk) begin
    if (rst)       carry_q <= '0;
    else if (step) carry_q <= sum >> WORD_W;
  end
endmodule

// File: rtl/sub_borrow.sv
// Third pass: word-serial subtraction with a borrow register.
module sub_borrow #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              first,
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  output logic [WORD_W-1:0] diff,
  output logic              borrow
);
  logic              borrow_q;
  logic              bin;
  logic [WORD_W:0]   full;

  assign bin    = first ? 1'b0 : borrow_q;
  assign full   = {1'b0, a} - {1'b0, b} - {{WORD_W{1'b0}}, bin};
  assign diff   = full[WORD_W-1:0];
  assign borrow = borrow_q;

  always_ff @(posedge clk) begin
    if (rst)       borrow_q <= 1'b0;
    else if (step) borrow_q <= full[WORD_W];
  end
endmodule

// File: rtl/mod2p_fold_reducer.sv
module mod2p_fold_reducer
  import red_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 8,
  parameter int EXT_W   = 40
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic [2*N_WORDS*WORD_W-1:0]   prod_in,
  input  logic [N_WORDS*WORD_W-1:0]     modulus_in,
  output logic                          busy,
  output logic                          done,
  output logic [N_WORDS*WORD_W-1:0]     result
);
  localparam int RES_W  = N_WORDS * WORD_W;
  localparam int PROD_W = 2 * RES_W;
  localparam int CNT_W  = $clog2(N_WORDS + 3);
  localparam int IDX_W  = $clog2(N_WORDS);
  localparam logic [CNT_W-1:0] C_NW    = CNT_W'(N_WORDS);
  localparam logic [CNT_W-1:0] C_LAST1 = CNT_W'(N_WORDS + 2);

  red_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  cnt_lo, prev_lo;
  logic [CNT_W-1:0]  prev_cnt;

  logic [PROD_W-1:0] prod_q;
  logic [RES_W-1:0]  mod_q;
  logic [RES_W-1:0]  res_q;
  logic              done_q;

  logic [WORD_W-1:0] lo_w  [N_WORDS];
  logic [WORD_W-1:0] hi_w  [N_WORDS];
  logic [WORD_W-1:0] mod_w [N_WORDS];
  logic [WORD_W-1:0] s1_q  [N_WORDS+1];
  logic [WORD_W-1:0] s2_q  [N_WORDS+1];
  logic [WORD_W-1:0] s2n_q [N_WORDS+1];
  logic [RES_W-1:0]  sel_res;

  logic accept;
  assign accept = (state_q == ST_IDLE) && start;

  for (genvar k = 0; k < N_WORDS; k++) begin : g_unpack
    assign lo_w[k]  = prod_q[k*WORD_W +: WORD_W];
    assign hi_w[k]  = prod_q[(N_WORDS+k)*WORD_W +: WORD_W];
    assign mod_w[k] = mod_q[k*WORD_W +: WORD_W];
  end

  assign cnt_lo   = cnt_q[IDX_W-1:0];
  assign prev_cnt = cnt_q - 1'b1;
  assign prev_lo  = prev_cnt[IDX_W-1:0];

  // ---------------- pass 1: L + 38*H ----------------
  logic              p1_issue;
  logic [WORD_W-1:0] p1_hcur, p1_hprev, p1_lcur;
  logic              s1_wr;
  logic [CNT_W-1:0]  s1_idx;
  logic [WORD_W-1:0] s1_word;

  always_comb begin
    p1_issue = (state_q == ST_FOLD1) && (cnt_q <= C_NW);
    p1_hcur  = (cnt_q < C_NW) ? hi_w[cnt_lo] : '0;
    p1_lcur  = (cnt_q < C_NW) ? lo_w[cnt_lo] : '0;
    p1_hprev = ((cnt_q != '0) && (cnt_q <= C_NW)) ? hi_w[prev_lo] : '0;
  end

  fold38_pipe #(.WORD_W(WORD_W), .EXT_W(EXT_W), .CNT_W(CNT_W)) u_pass1 (
    .clk     (clk),
    .rst     (rst),
    .clear   (accept),
    .issue   (p1_issue),
    .idx_in  (cnt_q),
    .h_cur   (p1_hcur),
    .h_prev  (p1_hprev),
    .l_cur   (p1_lcur),
    .wr_en   (s1_wr),
    .wr_idx  (s1_idx),
    .wr_word (s1_word)
  );

  // ---------------- pass 2: fold the spill-over ----------------
  logic [EXT_W-1:0]  spill, spill38;
  logic [WORD_W-1:0] p2_y, p2_sum;
  logic              p2_step;

  assign spill   = EXT_W'(s1_q[N_WORDS]);
  assign spill38 = (spill << 1) + (spill << 2) + (spill << 5);
  assign p2_step = (state_q == ST_FOLD2);
  assign p2_y    = (cnt_q < C_NW) ? s1_q[cnt_q] : '0;

  fold_carry #(.WORD_W(WORD_W), .EXT_W(EXT_W)) u_pass2 (
    .clk      (clk),
    .rst      (rst),
    .step     (p2_step),
    .first    (cnt_q == '0),
    .preload  (spill38),
    .y        (p2_y),
    .sum_word (p2_sum)
  );

  // ---------------- pass 3: trial subtraction ----------------
  logic [WORD_W-1:0] p3_b, p3_diff;
  logic              p3_step, p3_borrow;

  assign p3_step = (state_q == ST_SUB);
  assign p3_b    = (cnt_q < C_NW) ? mod_w[cnt_lo] : '0;

  sub_borrow #(.WORD_W(WORD_W)) u_pass3 (
    .clk    (clk),
    .rst    (rst),
    .step   (p3_step),
    .first  (cnt_q == '0),
    .a      (s2_q[cnt_q]),
    .b      (p3_b),
    .diff   (p3_diff),
    .borrow (p3_borrow)
  );

  for (genvar k = 0; k < N_WORDS; k++) begin : g_select
    assign sel_res[k*WORD_W +: WORD_W] = p3_borrow ? s2_q[k] : s2n_q[k];
  end

  // ---------------- data storage (no reset) ----------------
  always_ff @(posedge clk) begin
    if (accept) begin
      prod_q <= prod_in;
      mod_q  <= modulus_in;
    end
    if (s1_wr)   s1_q[s1_idx] <= s1_word;
    if (p2_step) s2_q[cnt_q]  <= p2_sum;
    if (p3_step) s2n_q[cnt_q] <= p3_diff;
  end

  // ---------------- sequencing ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      res_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_FOLD1;
            cnt_q   <= '0;
          end
        end
        ST_FOLD1: begin
          if (cnt_q == C_LAST1) begin
            state_q <= ST_FOLD2;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_FOLD2: begin
          if (cnt_q == C_NW) begin
            state_q <= ST_SUB;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_SUB: begin
          if (cnt_q == C_NW) begin
            state_q <= ST_FINISH;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_FINISH: begin
          res_q   <= sel_res;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (state_q != ST_IDLE);
  assign done   = done_q;
  assign result = res_q;
endmodule

// File: rtl/red_chk.sv
module red_chk #(
  parameter int RES_W = 256
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             done,
  input logic [RES_W-1:0] result,
  input logic [RES_W-1:0] mod_cap
);
  localparam logic [RES_W-1:0] TWO_P = {RES_W{1'b1}} - RES_W'(37);

  a_r2_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r2_busy_until_done: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || done));

  a_r2_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  a_r8_result_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));

  a_r5_below_modulus: assert property (@(posedge clk) disable iff (rst)
    (done && mod_cap == TWO_P) |-> (result < mod_cap));

  a_r9_modulus_held: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(mod_cap));
endmodule

bind mod2p_fold_reducer red_chk #(.RES_W(RES_W)) u_red_chk (
  .clk     (clk),
  .rst     (rst),
  .busy    (busy),
  .done    (done),
  .result  (result),
  .mod_cap (mod_q)
);

// File: tb/tb_mod2p_fold_reducer.sv
module tb_mod2p_fold_reducer;
  localparam int RES_W = 256;
  localparam int LAT   = 30;
  localparam logic [RES_W-1:0] TWO_P = {RES_W{1'b1}} - RES_W'(37);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [511:0]     prod = '0;
  logic [RES_W-1:0] modv = TWO_P;
  logic             busy, done;
  logic [RES_W-1:0] result;

  int checks = 0;
  int errors = 0;

  mod2p_fold_reducer dut (
    .clk(clk), .rst(rst), .start(start), .prod_in(prod),
    .modulus_in(modv), .busy(busy), .done(done), .result(result)
  );

  always #4 clk = ~clk;

  function automatic logic [RES_W-1:0] ref_reduce(input logic [511:0] c,
                                                  input logic [RES_W-1:0] n);
    logic [263:0] s1, s2, nn;
    s1 = {8'd0, c[255:0]} + ({8'd0, c[511:256]} * 264'd38);
    s2 = {8'd0, s1[255:0]} + ({256'd0, s1[263:256]} * 264'd38);
    nn = {8'd0, n};
    if (s2 >= nn) s2 = s2 - nn;
    return s2[255:0];
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [RES_W-1:0] act, input logic [RES_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference: remaining-cycles counter and queues of pending results
  int               m_cnt = 0;
  logic             exp_done = 1'b0;
  logic [RES_W-1:0] exp_q [$];
  logic [511:0]     prod_qq [$];
  logic [RES_W-1:0] mod_qq [$];
  logic [RES_W-1:0] last_res = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt    <= 0;
      exp_done <= 1'b0;
    end else begin
      exp_done <= (m_cnt == 1);
      if (m_cnt == 0 && start) begin
        m_cnt <= LAT;
        exp_q.push_back(ref_reduce(prod, modv));
        prod_qq.push_back(prod);
        mod_qq.push_back(modv);
      end else if (m_cnt > 0) m_cnt <= m_cnt - 1;
    end
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check(busy == (m_cnt != 0), "R2 busy", RES_W'(busy), RES_W'(m_cnt != 0));
      check(done == exp_done, "R2 done", RES_W'(done), RES_W'(exp_done));
      if (done && exp_q.size() > 0) begin
        logic [RES_W-1:0] e, n;
        logic [511:0]     c;
        e = exp_q.pop_front();
        c = prod_qq.pop_front();
        n = mod_qq.pop_front();
        check(result == e, "R4 result", result, e);
        if (n == TWO_P) begin
          check((c % {256'd0, TWO_P}) == ({256'd0, result} % {256'd0, TWO_P}),
                "R4 congruence", result, e);
          check(result < TWO_P, "R5 below modulus", result, TWO_P);
        end
        last_res = result;
      end else if (!done) begin
        check(result == last_res, "R8 result hold", result, last_res);
      end
    end
  end

  task automatic run_op(input logic [511:0] c, input logic [RES_W-1:0] n);
    @(negedge clk);
    prod  = c;
    modv  = n;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (LAT + 1) @(negedge clk);
  endtask

  task automatic check_last(input logic [RES_W-1:0] e, input string req);
    check(last_res == e, req, last_res, e);
  endtask

  function automatic logic [511:0] rep_hi(input logic [31:0] w);
    logic [511:0] v;
    v = '0;
    for (int k = 8; k < 16; k++) v[k*32 +: 32] = w;
    return v;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1: values during reset
    check(busy == 1'b0, "R1 busy in reset", RES_W'(busy), '0);
    check(done == 1'b0, "R1 done in reset", RES_W'(done), '0);
    check(result == '0, "R1 result in reset", result, '0);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && result == '0, "R1 after reset",
          result, '0);

    // R4: zero product
    run_op('0, TWO_P);
    check_last('0, "R4 zero product");

    // R5: boundary values around the modulus
    run_op({256'd0, TWO_P}, TWO_P);
    check_last('0, "R5 product equals modulus");
    run_op({256'd0, TWO_P - 256'd1}, TWO_P);
    check_last(TWO_P - 256'd1, "R5 modulus minus one kept");
    run_op({256'd0, TWO_P + 256'd5}, TWO_P);
    check_last(256'd5, "R5 modulus plus five");

    // R6: all ones
    run_op({512{1'b1}}, TWO_P);
    check_last(ref_reduce({512{1'b1}}, TWO_P), "R6 all ones");

    // R7: top-bit spill into next word and above the top high word
    run_op(rep_hi(32'h8000_0000), TWO_P);
    check_last(ref_reduce(rep_hi(32'h8000_0000), TWO_P), "R7 one-bit spill");
    run_op(rep_hi(32'hF800_0000), TWO_P);
    check_last(ref_reduce(rep_hi(32'hF800_0000), TWO_P), "R7 five-bit spill");
    run_op(512'd1 << 511, TWO_P);
    check_last(ref_reduce(512'd1 << 511, TWO_P), "R7 top bit only");

    // R4: random products
    for (int r = 0; r < 8; r++) begin
      logic [511:0] c;
      for (int k = 0; k < 16; k++) c[k*32 +: 32] = $urandom();
      run_op(c, TWO_P);
      check_last(ref_reduce(c, TWO_P), "R4 random product");
    end

    // R3 and R9: start and modulus changes while busy are ignored
    begin
      logic [511:0] c1, c2;
      logic [RES_W-1:0] e1;
      c1 = rep_hi(32'h1234_5678) | 512'h9abc_def0;
      c2 = {512{1'b1}};
      e1 = ref_reduce(c1, TWO_P);
      @(negedge clk);
      prod = c1; modv = TWO_P; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (5) @(negedge clk);
      prod = c2; start = 1'b1;      // R3: start while busy
      @(negedge clk);
      start = 1'b0;
      modv = {RES_W{1'b0}} | 256'h55;  // R9: modulus port changed mid-run
      repeat (LAT) @(negedge clk);
      check_last(e1, "R3 R9 start and modulus ignored while busy");
      check(busy == 1'b0, "R3 no second run", RES_W'(busy), '0);
      modv = TWO_P;
    end

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=<200000 cycles", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule